// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns four serial audio data lines into parallel stereo samples. All four lines share one bit clock and one frame clock, both driven from outside; the block is a pure slave running on the rising edge of the bit clock. A two-bit format input chooses between three framings:

- left-justified, where the word starts at the frame clock edge;
- right-justified, where the word ends at the frame clock edge;
- I2S, where the word starts one bit late and the frame clock polarity is inverted.

A two-bit length input chooses how many bits make up one sample.

Once per frame, after the right-channel word has been received, the block presents the left and right words of every lane together. A one-cycle strobe marks them. Surrounding logic reads the words while the strobe is high, or at any time before the next strobe, because the outputs hold their value between strobes.

Top module: `pcm_lane_rx`

## Requirements
- R1: With `fmt`=0 (left-justified; code 3 behaves the same), the MSB of a word is the data bit sampled on the first rising bit-clock edge at which `lrclk` is seen at its new level. The following N-1 edges carry the remaining bits, MSB first.
- R2: With `fmt`=2 (I2S), the MSB is the bit sampled on the second rising edge after the `lrclk` change. The first edge's bit is not part of the word.
- R3: With `fmt`=1 (right-justified), the word is the last N bits sampled before the edge that first sees the `lrclk` change. The LSB is the bit on the final edge of the half-frame.
- R4: In formats 0 and 1, `lrclk` high carries the left channel and `lrclk` low carries the right. In format 2 the polarity is reversed: low is left and high is right.
- R5: `wlen` codes 0, 1, 2 and 3 give N = 16, 20, 24 and 32 bits. Each sample is right-aligned in a 32-bit slot, with zeros above bit N-1.
- R6: In formats 0 and 2, bits in a half-frame beyond the N-bit window do not affect the result, whatever their value.
- R7: `valid` is high for exactly one cycle. That cycle follows the rising edge that first sees `lrclk` leave the right-channel level, so the strobe closes the frame whose right word just finished. `left_q` and `right_q` change only together with `valid`, and the strobe never appears at any other time.
- R8: Lane k is `sdata[k]`, and its samples appear in bits [32k+31:32k] of `left_q` and `right_q`. All lanes use the same timing and do not affect each other.
- R9: While `rst_n` is low, `valid` is 0 and both sample buses are 0. After reset, no strobe appears until one complete left half and one complete right half have followed the first `lrclk` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Frame clock selecting the channel |
| fmt | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S |
| wlen | input | 2 | Word length code: 16/20/24/32 bits |
| sdata | input | 4 | Serial data, one bit per lane |
| left_q | output | 128 | Left samples, 32 bits per lane |
| right_q | output | 128 | Right samples, 32 bits per lane |
| valid | output | 1 | One-cycle strobe: a new frame is on the sample buses |

## Verification
A wrong bit counter or a wrong shift window shows up as a sample moved by one bit position, or as junk bits leaking in. The bench gives every word all-ones, MSB-only or LSB-only values on some lanes and fills unused slots with random bits, so such an error appears in the very first frame's strobe. A wrong channel polarity or a fault in frame tracking shows as swapped words, a missing strobe or an extra strobe. The bench checks for these in the exact cycle after the frame edge and also counts stray strobes across each configuration.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

  localparam int unsigned SLOT = 32;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_I2S   = 2'd2
  } fmt_e;

  // sample length selected by the length code
  function automatic int unsigned word_bits(input logic [1:0] wl);
    case (wl)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

  // ones in the low word_bits positions
  function automatic logic [SLOT-1:0] word_mask(input logic [1:0] wl);
    logic [63:0] one;
    one = 64'd1 << word_bits(wl);
    return SLOT'(one - 64'd1);
  endfunction

  // bit index within the half-frame that carries the MSB
  function automatic int unsigned first_bit(input logic [1:0] f);
    return (f == FMT_I2S) ? 1 : 0;
  endfunction

  // frame clock level that marks the left channel
  function automatic logic left_level(input logic [1:0] f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/pcmrx_frame_ctl.sv
module pcmrx_frame_ctl
  import pcmrx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrclk,
  input  logic [1:0] fmt,
  input  logic [1:0] wlen,
  output logic       chg,
  output logic       word_done,
  output logic       shift_en,
  output logic       clr,
  output logic       prev_left
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic             lr_q, seen, primed;
  logic [CNT_W-1:0] cnt, idx;
  logic [CNT_W:0]   lo, hi, ix;

  assign chg       = seen && (lrclk != lr_q);
  assign word_done = chg && primed;
  assign idx       = chg ? '0 : ((cnt == SAT) ? cnt : cnt + CNT_W'(1));
  assign prev_left = (lr_q == left_level(fmt));
  assign clr       = chg && (fmt != FMT_RIGHT);

  always_comb begin
    lo = (CNT_W+1)'(first_bit(fmt));
    hi = lo + (CNT_W+1)'(word_bits(wlen));
    ix = {1'b0, idx};
    shift_en = (fmt == FMT_RIGHT) || ((ix >= lo) && (ix < hi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      seen   <= 1'b0;
      primed <= 1'b0;
      cnt    <= SAT;
    end else begin
      lr_q <= lrclk;
      seen <= 1'b1;
      cnt  <= idx;
      if (chg) primed <= 1'b1;
    end
  end
endmodule

// File: rtl/pcmrx_lane.sv
module pcmrx_lane
  import pcmrx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d,
  input  logic            clr,
  input  logic            shift_en,
  input  logic [SLOT-1:0] mask,
  output logic [SLOT-1:0] word
);
  logic [SLOT-1:0] sh, nxt;

  always_comb begin
    nxt = clr ? '0 : sh;
    if (shift_en) nxt = {nxt[SLOT-2:0], d};
  end

  assign word = sh & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= nxt;
  end
endmodule

// File: rtl/pcm_lane_rx.sv
module pcm_lane_rx
  import pcmrx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 6
) (
  input  logic                  bclk,
  input  logic                  rst_n,
  input  logic                  lrclk,
  input  logic [1:0]            fmt,
  input  logic [1:0]            wlen,
  input  logic [LANES-1:0]      sdata,
  output logic [LANES*SLOT-1:0] left_q,
  output logic [LANES*SLOT-1:0] right_q,
  output logic                  valid
);
  logic chg, word_done, shift_en, clr, prev_left, left_ok;
  logic [SLOT-1:0]             mask;
  logic [LANES-1:0][SLOT-1:0]  lane_word, hold, l_r, r_r;

  assign mask = word_mask(wlen);

  pcmrx_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(bclk), .rst_n(rst_n), .lrclk(lrclk), .fmt(fmt), .wlen(wlen),
    .chg(chg), .word_done(word_done), .shift_en(shift_en), .clr(clr),
    .prev_left(prev_left)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pcmrx_lane u_lane (
      .clk(bclk), .rst_n(rst_n), .d(sdata[g]), .clr(clr),
      .shift_en(shift_en), .mask(mask), .word(lane_word[g])
    );
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      l_r     <= '0;
      r_r     <= '0;
      left_ok <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (word_done) begin
        if (prev_left) begin
          hold    <= lane_word;
          left_ok <= 1'b1;
        end else if (left_ok) begin
          l_r     <= hold;
          r_r     <= lane_word;
          valid   <= 1'b1;
          left_ok <= 1'b0;
        end
      end
    end
  end

  assign left_q  = l_r;
  assign right_q = r_r;
endmodule

// File: rtl/pcm_lane_rx_chk.sv
module pcm_lane_rx_chk
  import pcmrx_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lrclk,
  input logic [1:0]            wlen,
  input logic                  valid,
  input logic [LANES*SLOT-1:0] left_q,
  input logic [LANES*SLOT-1:0] right_q,
  input logic                  word_done
);
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != $past(left_q)) |-> valid);

  a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (right_q != $past(right_q)) |-> valid);

  a_r7_done_on_lr_edge: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (lrclk != $past(lrclk)));

  for (genvar g = 0; g < LANES; g++) begin : g_ext
    a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (((left_q[g*SLOT +: SLOT] | right_q[g*SLOT +: SLOT])
                  & ~word_mask(wlen)) == '0));
  end
endmodule

bind pcm_lane_rx pcm_lane_rx_chk #(.LANES(LANES)) u_chk (
  .clk(bclk), .rst_n(rst_n), .lrclk(lrclk), .wlen(wlen), .valid(valid),
  .left_q(left_q), .right_q(right_q), .word_done(word_done)
);

// File: tb/pcm_lane_rx_bench.sv
module pcm_lane_rx_bench;
  localparam int FR = 3;

  logic         bclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lrclk = 1'b0;
  logic [1:0]   fmt = 2'd0;
  logic [1:0]   wlen = 2'd0;
  logic [3:0]   sdata = 4'd0;
  logic [127:0] left_q, right_q;
  logic         valid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] exp_l [FR][4];
  logic [31:0] exp_r [FR][4];

  always #10 bclk = ~bclk;

  pcm_lane_rx u_pcm_lane_rx (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .fmt(fmt), .wlen(wlen),
    .sdata(sdata), .left_q(left_q), .right_q(right_q), .valid(valid)
  );

  always @(posedge bclk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 15);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run_cfg(input int f, input int wl, input int extra);
    int n, h_len, stray;
    logic lft_lvl;
    logic [31:0] msk, w;
    string mtag;
    n = (wl == 3) ? 32 : 16 + 4 * wl;
    h_len = n + extra + ((f == 2) ? 1 : 0);
    msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    lft_lvl = (f == 2) ? 1'b0 : 1'b1;
    mtag = (f == 0) ? "R1" : (f == 1) ? "R3" : "R2";
    if (extra > 0) mtag = {mtag, " R6"};
    stray = 0;

    @(negedge bclk);
    rst_n = 1'b0;
    fmt = 2'(f);
    wlen = 2'(wl);
    lrclk = ~lft_lvl;
    sdata = 4'd0;
    repeat (2) @(negedge bclk);
    check(valid == 1'b0, "R9 reset valid", {31'd0, valid}, 32'd0);
    check(left_q == '0 && right_q == '0, "R9 reset samples",
          left_q[31:0] | right_q[31:0], 32'd0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge bclk);
      if (valid) stray++;
    end

    for (int fr = 0; fr < FR; fr++)
      for (int ln = 0; ln < 4; ln++) begin
        exp_l[fr][ln] = rnd() & msk;
        exp_r[fr][ln] = rnd() & msk;
      end
    exp_l[0][0] = msk;
    exp_r[0][0] = 32'd0;
    exp_l[0][1] = 32'd1 << (n - 1);
    exp_r[0][1] = 32'd1;
    exp_l[0][2] = 32'd1;
    exp_r[0][2] = msk;

    for (int h = 0; h <= 2 * FR; h++) begin
      logic is_left;
      is_left = (h % 2) == 0;
      for (int j = 0; j < h_len; j++) begin
        @(negedge bclk);
        if (j == 1 && is_left && h >= 2) begin
          check(valid == 1'b1, "R7 strobe after frame edge", {31'd0, valid}, 32'd1);
          for (int ln = 0; ln < 4; ln++) begin
            check(left_q[ln*32 +: 32] == exp_l[h/2-1][ln],
                  $sformatf("%s R4 R5 R8 lane%0d left wl=%0d", mtag, ln, n),
                  left_q[ln*32 +: 32], exp_l[h/2-1][ln]);
            check(right_q[ln*32 +: 32] == exp_r[h/2-1][ln],
                  $sformatf("%s R4 R5 R8 lane%0d right wl=%0d", mtag, ln, n),
                  right_q[ln*32 +: 32], exp_r[h/2-1][ln]);
          end
        end else if (valid) begin
          stray++;
        end
        lrclk = is_left ? lft_lvl : ~lft_lvl;
        for (int ln = 0; ln < 4; ln++) begin
          logic b;
          w = (h == 2 * FR) ? rnd() : (is_left ? exp_l[h/2][ln] : exp_r[h/2][ln]);
          b = rnd()[7];
          if (f == 0 && j < n)                 b = w[n-1-j];
          else if (f == 2 && j >= 1 && j <= n) b = w[n-j];
          else if (f == 1 && j >= h_len - n)   b = w[h_len-1-j];
          sdata[ln] = b;
        end
      end
    end
    repeat (4) begin
      @(negedge bclk);
      if (valid) stray++;
    end
    check(stray == 0, "R7 R9 no stray strobe", 32'(stray), 32'd0);
  endtask

  initial begin
    for (int f = 0; f < 3; f++)
      for (int wl = 0; wl < 4; wl++) begin
        run_cfg(f, wl, 0);
        run_cfg(f, wl, 5);
      end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule